// File: doc/BRIEF.md
# Memory Write-Readback Pattern Tester

This block checks an external word-addressed memory without holding any copy of the expected contents. A run has two phases. In the fill phase every address, lowest first, receives one word from a 32-bit pseudo-random generator. In the check phase the generator is restarted from the same seed. Each address is then read back in the same order and compared with the regenerated word. One mismatch anywhere marks the run as failed. The check phase still visits every address.

The memory side is a simple request/acknowledge port. A request is held until it is acknowledged. Reads return through a separate valid strobe, and only one read is outstanding at a time. A start input launches a run, and raising it again aborts any run in progress and repeats the test from the beginning. While start is held the block reports busy and issues nothing. The run begins once start falls. At the end, a pass or fail indication is held steadily until the next start. A free-running heartbeat output shows that the clock is alive.

Top module: `mem_pattern_tester`

## Requirements
- R1: While reset is low and on the cycle after it, busy, pass, fail, req_valid and heartbeat are all 0.
- R2: heartbeat is bit HB_W-1 of a counter that is cleared by reset and advances every cycle. With the default HB_W=4 it toggles every 8 cycles, whatever the state of the test.
- R3: While start is high, busy is 1, pass and fail are 0 and req_valid is 0. Start takes precedence in every state, so a run in progress is abandoned. The first write request appears on the cycle after start is first sampled low.
- R4: The fill phase writes each address from 0 to 2^ADDR_W-1, once each and in ascending order (req_write=1). The first word is the seed 32'h1ACE_B00C. Each following word is {x[30:0], x[31]^x[21]^x[1]^x[0]} of the previous word x.
- R5: While req_valid is 1 and req_ack is 0, req_valid, req_write, req_addr and req_wdata keep their values. The next request appears on the cycle after the acknowledge.
- R6: No read request (req_valid=1, req_write=0) is issued until every address has been written. Reads cover the same ascending address order. After a read is acknowledged, no further request is issued until rd_valid returns the data.
- R7: rd_data is taken only when rd_valid is high while a read is outstanding. rd_valid pulses with arbitrary data at any other time have no effect on the result.
- R8: Each returned word is compared with the generator restarted from the same seed. Any mismatch sets a fail flag that stays set for the rest of the run, and the check phase still completes all 2^ADDR_W reads.
- R9: After the last read, busy is 0 and exactly one of pass or fail is 1: pass if no word mismatched, fail otherwise. The value is held steadily until start is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch or repeat a run; the run begins when it falls |
| req_valid | output | 1 | Memory request present |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | ADDR_W | Word address of the request |
| req_wdata | output | 32 | Write data |
| req_ack | input | 1 | Memory accepts the current request |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Start held or run in progress |
| pass | output | 1 | Finished run with no mismatch |
| fail | output | 1 | Finished run with at least one mismatch |
| heartbeat | output | 1 | Free-running clock-alive toggle |

## Verification
Every result depends on a registered state, so it appears on the cycle after the edge that samples the cause. Busy appears one cycle after start is sampled high. The first write appears one cycle after start is sampled low. Request fields advance one cycle after an acknowledge, and the pass or fail verdict appears one cycle after the last rd_valid. The bench drives inputs at the falling edge and advances its own behavioural model at the rising edge. It then compares status, request fields and heartbeat at the next falling edge, so every expected value lands in exactly the cycle it is due. The bench's memory responder varies the acknowledge and read latencies and injects stray rd_valid pulses. In one run it corrupts a single stored word.

// File: rtl/mpt_pkg.sv
// Shared types and helpers for the memory pattern tester.
// Assumes a fixed 32-bit pattern width; the generator polynomial is
// x^32 + x^22 + x^2 + x + 1 in Fibonacci form.
package mpt_pkg;

    localparam int PAT_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_WRITE = 3'd2,
        ST_RREQ  = 3'd3,
        ST_RWAIT = 3'd4,
        ST_DONE  = 3'd5
    } mpt_state_e;

    // One step of the maximal-length pattern generator.
    function automatic logic [PAT_W-1:0] pat_advance(input logic [PAT_W-1:0] x);
        return {x[PAT_W-2:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

endpackage

// File: rtl/mpt_lfsr.sv
// Pattern generator: holds the current test word and either restarts from
// SEED or advances one step. Assumes SEED is nonzero, so the value never
// reaches the all-zero lock-up state.
module mpt_lfsr
    import mpt_pkg::*;
#(
    parameter logic [PAT_W-1:0] SEED = 32'h1ACE_B00C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    output logic [PAT_W-1:0] value
);

    // Hold, restart or advance the pattern word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= SEED;
        end else if (load) begin
            value <= SEED;
        end else if (advance) begin
            value <= pat_advance(value);
        end
    end

    // R4: a maximal-length generator never produces zero
    a_r4_pattern_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        value != '0);

endmodule

// File: rtl/mpt_addr_ctr.sv
// Word address counter shared by both phases. Clear returns it to 0;
// increment steps it by one. Assumes the sequencer never requests both
// in the same cycle and stops a phase when at_last is reached.
module mpt_addr_ctr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] ADDR_ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + ADDR_ONE;
        end
    end

    // Last-address detect ends a phase.
    assign at_last = (addr == ADDR_LAST);

    // R6: the counter is never stepped past the top of the space
    a_r6_no_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && at_last));

endmodule

// File: rtl/mpt_heartbeat.sv
// Free-running clock-alive indicator. Output is the top bit of an HB_W-bit
// counter, toggling every 2^(HB_W-1) cycles. Assumes HB_W >= 2.
module mpt_heartbeat #(
    parameter int HB_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic beat
);

    localparam logic [HB_W-1:0] HB_ONE = {{(HB_W-1){1'b0}}, 1'b1};

    logic [HB_W-1:0] cnt;

    // Divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + HB_ONE;
        end
    end

    // Heartbeat tap.
    assign beat = cnt[HB_W-1];

endmodule

// File: rtl/mpt_seq.sv
// Run sequencer: start handling, fill phase, one-at-a-time read phase,
// word compare and the sticky result. Assumes the memory acknowledges each
// request eventually and returns exactly one rd_valid per accepted read.
module mpt_seq
    import mpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             req_ack,
    input  logic             rd_valid,
    input  logic [PAT_W-1:0] rd_data,
    input  logic [PAT_W-1:0] pattern,
    input  logic             at_last,
    output logic             ctr_clear,
    output logic             ctr_inc,
    output logic             pat_load,
    output logic             pat_step,
    output logic             req_valid,
    output logic             req_write,
    output logic             busy,
    output logic             pass,
    output logic             fail
);

    mpt_state_e state, state_nxt;
    logic       bad_seen;
    logic       wr_taken, rd_taken, launch, mismatch;

    // Event decode for the current cycle.
    always_comb begin
        wr_taken  = (state == ST_WRITE) && req_ack;
        rd_taken  = (state == ST_RWAIT) && rd_valid;
        launch    = (state == ST_HOLD);
        mismatch  = rd_taken && (rd_data != pattern);
        ctr_clear = !start && (launch || (wr_taken && at_last));
        ctr_inc   = !start && (wr_taken || rd_taken) && !at_last;
        pat_load  = ctr_clear;
        pat_step  = ctr_inc;
    end

    // Next-state selection; start overrides every state.
    always_comb begin
        state_nxt = state;
        if (start) begin
            state_nxt = ST_HOLD;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_HOLD:  state_nxt = ST_WRITE;
                ST_WRITE: if (wr_taken && at_last) state_nxt = ST_RREQ;
                ST_RREQ:  if (req_ack) state_nxt = ST_RWAIT;
                ST_RWAIT: if (rd_taken) state_nxt = at_last ? ST_DONE : ST_RREQ;
                ST_DONE:  state_nxt = ST_DONE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Sticky mismatch flag, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_seen <= 1'b0;
        end else if (start) begin
            bad_seen <= 1'b0;
        end else if (mismatch) begin
            bad_seen <= 1'b1;
        end
    end

    // Request and status decode from registered state.
    always_comb begin
        req_valid = (state == ST_WRITE) || (state == ST_RREQ);
        req_write = (state == ST_WRITE);
        busy      = (state == ST_HOLD) || (state == ST_WRITE) ||
                    (state == ST_RREQ) || (state == ST_RWAIT);
        pass      = (state == ST_DONE) && !bad_seen;
        fail      = (state == ST_DONE) && bad_seen;
    end

    // R3: a sampled start quiets the request port and shows busy
    a_r3_start_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !req_valid && !pass && !fail));

    // R6: no new request while a read is outstanding
    a_r6_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RWAIT && !rd_valid && !start) |=> !req_valid);

    // R8: a mismatch is never forgotten within a run
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_seen && !start) |=> bad_seen);

    // R9: a pass verdict holds until the next start
    a_r9_pass_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && !start) |=> (pass && !fail && !busy));

endmodule

// File: rtl/mem_pattern_tester.sv
// Top of the memory write-readback pattern tester. Wires the sequencer,
// address counter, pattern generator and heartbeat. Assumes a word-
// addressed memory with 2^ADDR_W locations of 32 bits.
module mem_pattern_tester
    import mpt_pkg::*;
#(
    parameter int               ADDR_W = 4,
    parameter logic [PAT_W-1:0] SEED   = 32'h1ACE_B00C,
    parameter int               HB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [PAT_W-1:0]  req_wdata,
    input  logic              req_ack,
    input  logic              rd_valid,
    input  logic [PAT_W-1:0]  rd_data,
    output logic              busy,
    output logic              pass,
    output logic              fail,
    output logic              heartbeat
);

    logic             ctr_clear, ctr_inc, pat_load, pat_step, at_last;
    logic [PAT_W-1:0] pattern;

    mpt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_ack   (req_ack),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .pattern   (pattern),
        .at_last   (at_last),
        .ctr_clear (ctr_clear),
        .ctr_inc   (ctr_inc),
        .pat_load  (pat_load),
        .pat_step  (pat_step),
        .req_valid (req_valid),
        .req_write (req_write),
        .busy      (busy),
        .pass      (pass),
        .fail      (fail)
    );

    mpt_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .inc     (ctr_inc),
        .addr    (req_addr),
        .at_last (at_last)
    );

    mpt_lfsr #(.SEED(SEED)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pat_load),
        .advance (pat_step),
        .value   (pattern)
    );

    mpt_heartbeat #(.HB_W(HB_W)) u_hb (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (heartbeat)
    );

    // Write data is the live pattern word.
    assign req_wdata = pattern;

    // R5: an unacknowledged request is held unchanged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack && !start) |=>
        (req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_wdata)));

endmodule

// File: tb/tb_mem_pattern_tester.sv
`timescale 1ns/1ps
module tb_mem_pattern_tester;

    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HB_W   = 4;
    localparam logic [31:0] SEED = 32'h1ACE_B00C;
    localparam int S_IDLE = 0, S_HOLD = 1, S_WRITE = 2, S_RREQ = 3, S_RWAIT = 4, S_DONE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic req_ack = 1'b0;
    logic rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic req_valid, req_write, busy, pass, fail, heartbeat;
    logic [ADDR_W-1:0] req_addr;
    logic [31:0] req_wdata;

    mem_pattern_tester #(.ADDR_W(ADDR_W), .SEED(SEED), .HB_W(HB_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .pass(pass), .fail(fail),
        .heartbeat(heartbeat)
    );

    always #2 clk = ~clk;

    // reference model state
    int m_state, m_addr, m_hb;
    logic [31:0] m_lfsr;
    bit m_fail;
    // memory responder state
    logic [31:0] mem [DEPTH];
    int ack_wait, rd_delay, lat_sel, writes_seen, reads_seen, spurious;
    bit rd_pend, fault_en, cmp_en;
    logic [31:0] rd_buf;
    // latched outputs
    logic o_busy, o_pass, o_fail, o_v, o_w, o_hb;
    logic [ADDR_W-1:0] o_addr;
    logic [31:0] o_wdata;
    int checks = 0, failures = 0, cyc = 0;

    function automatic logic [31:0] nxt(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [63:0] ea, aa;
        bit ev, ew;
        ea = {61'd0, (m_state >= S_HOLD && m_state <= S_RWAIT),
              (m_state == S_DONE && !m_fail), (m_state == S_DONE && m_fail)};
        aa = {61'd0, o_busy, o_pass, o_fail};
        check(aa === ea, "R3|R9 status", aa, ea);
        ev = (m_state == S_WRITE) || (m_state == S_RREQ);
        ew = (m_state == S_WRITE);
        ea = {26'd0, ev, ew, ev ? 4'(m_addr) : 4'd0, ew ? m_lfsr : 32'd0};
        aa = {26'd0, o_v, o_v & o_w, o_v ? o_addr : 4'd0, (o_v && o_w) ? o_wdata : 32'd0};
        check(aa === ea, "R4 R5 R6 request", aa, ea);
        ea = 64'((m_hb >> (HB_W - 1)) & 1);
        aa = {63'd0, o_hb};
        check(aa === ea, "R2 heartbeat", aa, ea);
    endtask

    task automatic model_update();
        if (!rst_n) begin
            m_state = S_IDLE; m_fail = 0; m_addr = 0; m_lfsr = SEED; m_hb = 0;
        end else begin
            m_hb = (m_hb + 1) % (1 << HB_W);
            if (start) begin
                m_state = S_HOLD; m_fail = 0;
            end else begin
                case (m_state)
                    S_HOLD: begin m_state = S_WRITE; m_addr = 0; m_lfsr = SEED; end
                    S_WRITE: if (req_ack) begin
                        if (m_addr == DEPTH - 1) begin m_state = S_RREQ; m_addr = 0; m_lfsr = SEED; end
                        else begin m_addr++; m_lfsr = nxt(m_lfsr); end
                    end
                    S_RREQ: if (req_ack) m_state = S_RWAIT;
                    S_RWAIT: if (rd_valid) begin
                        if (rd_data !== m_lfsr) m_fail = 1;
                        if (m_addr == DEPTH - 1) m_state = S_DONE;
                        else begin m_addr++; m_lfsr = nxt(m_lfsr); m_state = S_RREQ; end
                    end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic responder_update();
        if (!rst_n || start) begin
            writes_seen = 0; reads_seen = 0;
        end
        if (!rst_n) begin
            rd_pend = 0; ack_wait = 0;
        end
        if (rd_pend) begin
            if (rd_valid) rd_pend = 0;
            else rd_delay--;
        end
        if (req_ack) begin
            if (o_w) begin
                mem[o_addr] = o_wdata ^ ((fault_en && o_addr == 5) ? 32'h0000_0080 : 32'h0);
                writes_seen++;
            end else begin
                check(writes_seen == DEPTH, "R6 read after full fill", 64'(writes_seen), 64'(DEPTH));
                rd_pend = 1; rd_buf = mem[o_addr]; rd_delay = lat_sel % 2; reads_seen++;
            end
            ack_wait = lat_sel % 3;
            lat_sel++;
        end else if (o_v && ack_wait > 0) begin
            ack_wait--;
        end
    endtask

    task automatic step(input bit s);
        @(negedge clk);
        o_busy = busy; o_pass = pass; o_fail = fail; o_v = req_valid; o_w = req_write;
        o_addr = req_addr; o_wdata = req_wdata; o_hb = heartbeat;
        if (cmp_en) compare_all();
        start = s; req_ack = 0; rd_valid = 0;
        if (rd_pend) begin
            if (rd_delay == 0) begin rd_valid = 1; rd_data = rd_buf; end
        end else if (cyc % 7 == 3) begin
            rd_valid = 1; rd_data = 32'hBAD0_0000 ^ 32'(cyc); spurious++;
        end
        if (!s && o_v && ack_wait == 0 && !rd_pend) req_ack = 1;
        @(posedge clk);
        model_update();
        responder_update();
        cyc++;
        #1;
    endtask

    task automatic run_to_done(input string tag);
        for (int i = 0; i < 3000; i++) begin
            if (m_state == S_DONE) break;
            step(0);
        end
        if (m_state != S_DONE) check(0, {"watchdog ", tag}, 64'(m_state), 64'(S_DONE));
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        lat_sel = 0; spurious = 0; fault_en = 0; cmp_en = 0;
        @(posedge clk);
        model_update(); responder_update();
        #1;
        cmp_en = 1;
        step(0); step(0);
        // R1 reset state
        check({busy, pass, fail, req_valid, heartbeat} === 5'b0, "R1 reset outputs",
              64'({busy, pass, fail, req_valid, heartbeat}), 64'd0);
        rst_n = 1'b1;
        step(0);
        check({busy, pass, fail, req_valid} === 4'b0, "R1 idle after reset",
              64'({busy, pass, fail, req_valid}), 64'd0);

        // run A: clean memory, stray rd_valid pulses
        step(1); step(1); step(1);
        check(busy === 1'b1 && req_valid === 1'b0, "R3 held start shows busy",
              64'({busy, req_valid}), 64'b10);
        run_to_done("run A");
        check(pass === 1'b1 && fail === 1'b0, "R9 clean run passes", 64'({pass, fail}), 64'b10);
        check(writes_seen == DEPTH, "R4 every address written once", 64'(writes_seen), 64'(DEPTH));
        check(spurious > 0 && pass === 1'b1, "R7 stray strobes ignored", 64'(pass), 64'd1);
        begin
            int toggles = 0;
            logic prev;
            prev = heartbeat;
            for (int i = 0; i < 32; i++) begin
                step(0);
                if (heartbeat !== prev) toggles++;
                prev = heartbeat;
                check(pass === 1'b1, "R9 pass held steady", 64'(pass), 64'd1);
            end
            check(toggles == 4, "R2 heartbeat toggles every 8 cycles", 64'(toggles), 64'd4);
        end

        // run B: one corrupted word
        fault_en = 1;
        step(1); step(1);
        run_to_done("run B");
        check(fail === 1'b1 && pass === 1'b0, "R8 corrupted word fails", 64'({pass, fail}), 64'b01);
        check(reads_seen == DEPTH, "R8 read phase completes", 64'(reads_seen), 64'(DEPTH));
        for (int i = 0; i < 10; i++) step(0);
        check(fail === 1'b1 && busy === 1'b0, "R9 fail held steady", 64'({fail, busy}), 64'b10);

        // run C: abort during read phase, then rerun clean
        fault_en = 0;
        step(1);
        check(fail === 1'b0 && busy === 1'b1, "R3 start clears verdict", 64'({fail, busy}), 64'b01);
        for (int i = 0; i < 3000; i++) begin
            if (m_state == S_RREQ || m_state == S_RWAIT) break;
            step(0);
        end
        for (int i = 0; i < 4; i++) step(0);
        step(1); step(1);
        check(busy === 1'b1 && req_valid === 1'b0, "R3 abort mid-read", 64'({busy, req_valid}), 64'b10);
        step(0);
        check(req_valid === 1'b1 && req_write === 1'b1 && req_addr === '0 && req_wdata === SEED,
              "R3 R4 restart at address 0 with seed", 64'(req_wdata), 64'(SEED));
        run_to_done("run C");
        check(pass === 1'b1 && fail === 1'b0, "R3 rerun passes", 64'({pass, fail}), 64'b10);

        $display("%0d/%0d checks passed", checks - failures, checks);
        $finish;
    end

endmodule